// File: doc/BRIEF.md
# SPI Slave Register-Access Bridge

This block is an SPI slave that gives an external master byte-wide access to a 32 KB address space inside the chip. A transaction is framed by an active-low chip select. The master first sends an opcode byte that picks read or write. It then sends a 16-bit start address, most significant byte first. After that it may clock any number of data bytes, and the address steps by one after each byte. While the three header bytes arrive, the slave returns a fixed count pattern on MISO, which lets the master confirm that the link is alive.

The SPI pins are oversampled by a system clock that runs many times faster than SCLK. Two-flop synchronisers and edge detection in that clock domain turn the serial stream into byte events. These events drive a small backing RAM through a plain synchronous port: address, write data, write enable and registered read data. The RAM holds 2^MEM_AW bytes, and the address bits above MEM_AW alias onto it. The full 15-bit address 0x0080 is a fixed read-only identification register.

Top module: `spi_bridge`

## Requirements
- R1: A first byte of 0x0F starts a read transaction and a first byte of 0xF0 starts a write transaction.
- R2: The next two bytes form the start address, high byte first. Bit 7 of the high byte is ignored, so addresses are 15 bits wide.
- R3: During the opcode byte and the two address bytes, MISO carries 0x00, then 0x01, then 0x02.
- R4: On a read, each data byte returns the content of the current address, starting at the start address and then the following locations, for as long as the master keeps clocking.
- R5: On a write, each complete data byte is stored at the current address, and the address then advances by one.
- R6: During the data bytes of a write, MISO carries 0x00.
- R7: Address 0x0080 always reads as 0x51, and a write to it leaves that value unchanged.
- R8: Any other opcode causes the rest of the transaction to be ignored. No memory location changes, and MISO stays 0x00 until chip select rises.
- R9: Raising chip select at any point ends the transaction and drops any partly received byte. The next transaction then starts again at the opcode.
- R10: During a burst, the address wraps from 0x7FFF to 0x0000.
- R11: The interface uses SPI mode 3 with MSB first. The slave samples MOSI on SCLK rising edges and changes MISO on falling edges. MISO is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |

## Verification
The bench aims at the byte boundaries, where the phase changes. If the header pattern were off by one byte, the master would get 0x01 where it expects 0x00. If the design were slow to fetch the first read byte, that byte would carry stale data. A write burst that runs across the identification register must keep that register at 0x51. An abort in the middle of a byte must not leave bits behind: if it did, the next opcode would be shifted and the master would read back zeros. The wrap test reads a burst that crosses 0x7FFF. A 16-bit counter would miss the identification register on the far side, and a missing increment would repeat bytes.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

    localparam int ADDR_W = 15;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_READ   = 8'h0F;
    localparam logic [BYTE_W-1:0] OP_WRITE  = 8'hF0;
    localparam logic [ADDR_W-1:0] ID_ADDR   = 15'h0080;
    localparam logic [BYTE_W-1:0] ID_VALUE  = 8'h51;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_DATA,
        PH_IGNORE
    } phase_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // Byte sent on MISO while a header byte is being received
    function automatic logic [BYTE_W-1:0] header_tag(input phase_t ph);
        case (ph)
            PH_ADDR_HI: header_tag = 8'h01;
            PH_ADDR_LO: header_tag = 8'h02;
            default:    header_tag = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
    parameter int           W    = 3,
    parameter logic [W-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= IDLE[g];
                sync_q <= IDLE[g];
            end else begin
                meta_q <= din[g];
                sync_q <= meta_q;
            end
        end
        assign dout[g] = sync_q;
    end
endmodule

// File: rtl/spi_bridge_regfile.sv
module spi_bridge_regfile
    import spi_bridge_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_req.en && wr_req.addr != ID_ADDR)
            mem[wr_req.addr[MEM_AW-1:0]] <= wr_req.data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_addr == ID_ADDR)
            rd_data <= ID_VALUE;
        else
            rd_data <= mem[rd_addr[MEM_AW-1:0]];
    end
endmodule

// File: rtl/spi_bridge_frame.sv
module spi_bridge_frame
    import spi_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              cs_active,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              miso,
    output logic [ADDR_W-1:0] cur_addr,
    output wr_req_t           wr_req,
    output phase_t            phase,
    output logic              is_read
);
    logic              sclk_prev;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_shift;
    logic [6:0]        addr_hi;
    logic [BYTE_W-1:0] tx_shift;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] next_byte;
    logic              sclk_rise, sclk_fall;

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;
    assign rx_byte   = {rx_shift, mosi_s};

    always_comb begin
        if (phase == PH_DATA)
            next_byte = is_read ? rd_data : 8'h00;
        else
            next_byte = header_tag(phase);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b1;
            bit_cnt   <= '0;
            rx_shift  <= '0;
            addr_hi   <= '0;
            tx_shift  <= '0;
            miso      <= 1'b0;
            cur_addr  <= '0;
            wr_req    <= '0;
            phase     <= PH_OPCODE;
            is_read   <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            wr_req.en <= 1'b0;
            if (!cs_active) begin
                phase    <= PH_OPCODE;
                bit_cnt  <= '0;
                rx_shift <= '0;
                miso     <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    bit_cnt  <= bit_cnt + 3'd1;
                    rx_shift <= rx_byte[6:0];
                    if (bit_cnt == 3'd7) begin
                        case (phase)
                            PH_OPCODE: begin
                                if (rx_byte == OP_READ) begin
                                    is_read <= 1'b1;
                                    phase   <= PH_ADDR_HI;
                                end else if (rx_byte == OP_WRITE) begin
                                    is_read <= 1'b0;
                                    phase   <= PH_ADDR_HI;
                                end else begin
                                    phase   <= PH_IGNORE;
                                end
                            end
                            PH_ADDR_HI: begin
                                addr_hi <= rx_byte[6:0];
                                phase   <= PH_ADDR_LO;
                            end
                            PH_ADDR_LO: begin
                                cur_addr <= {addr_hi, rx_byte};
                                phase    <= PH_DATA;
                            end
                            PH_DATA: begin
                                if (!is_read) begin
                                    wr_req.en   <= 1'b1;
                                    wr_req.addr <= cur_addr;
                                    wr_req.data <= rx_byte;
                                end
                                cur_addr <= cur_addr + 1'b1;
                            end
                            default: phase <= PH_IGNORE;
                        endcase
                    end
                end
                if (sclk_fall) begin
                    if (bit_cnt == 3'd0) begin
                        miso     <= next_byte[7];
                        tx_shift <= {next_byte[6:0], 1'b0};
                    end else begin
                        miso     <= tx_shift[7];
                        tx_shift <= {tx_shift[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_bridge.sv
module spi_bridge
    import spi_bridge_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    logic [2:0]        pins_s;
    logic              cs_active;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0] rd_data;
    wr_req_t           wr_req;
    phase_t            phase;
    logic              is_read;

    spi_bridge_sync #(.W(3), .IDLE(3'b110)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({spi_sclk, spi_cs_n, spi_mosi}),
        .dout (pins_s)
    );

    assign cs_active = ~pins_s[1];

    spi_bridge_frame i_frame (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[2]),
        .cs_active (cs_active),
        .mosi_s    (pins_s[0]),
        .rd_data   (rd_data),
        .miso      (spi_miso),
        .cur_addr  (cur_addr),
        .wr_req    (wr_req),
        .phase     (phase),
        .is_read   (is_read)
    );

    spi_bridge_regfile #(.MEM_AW(MEM_AW)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .rd_addr (cur_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/spi_bridge_chk.sv
module spi_bridge_chk
    import spi_bridge_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_active,
    input logic              miso,
    input phase_t            phase,
    input wr_req_t           wr_req,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              is_read
);
    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> !miso); // R11

    AST_CS_ABORT: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> phase == PH_OPCODE); // R9

    AST_WR_IN_WRITE_DATA: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |-> (!is_read && phase == PH_DATA)); // R5

    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |-> cur_addr == ADDR_W'(wr_req.addr + 1'b1)); // R10

    AST_IGNORE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        phase == PH_IGNORE |-> !wr_req.en); // R8

    AST_IGNORE_MISO_LOW: assert property (@(posedge clk) disable iff (rst)
        phase == PH_IGNORE |-> !miso); // R8
endmodule

bind spi_bridge spi_bridge_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_active (cs_active),
    .miso      (spi_miso),
    .phase     (phase),
    .wr_req    (wr_req),
    .cur_addr  (cur_addr),
    .is_read   (is_read)
);

// File: tb/test_spi_bridge.sv
module test_spi_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;   // system clocks per SCLK half period

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b1;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_bridge i_spi_bridge (
        .clk      (clk),
        .rst      (rst),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_sclk = 1'b0;
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic partial(input logic [7:0] tx, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_sclk = 1'b0;
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic cs_low();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    // Sends the opcode and address, checks the header pattern
    task automatic header(input logic [7:0] op, input logic [15:0] addr, input string req);
        logic [7:0] rx;
        xfer(op, rx);           check({req, " R3 hdr0"}, rx, 8'h00);
        xfer(addr[15:8], rx);   check({req, " R3 hdr1"}, rx, 8'h01);
        xfer(addr[7:0], rx);    check({req, " R3 hdr2"}, rx, 8'h02);
    endtask

    task automatic write_bytes(input logic [15:0] addr, input logic [7:0] d0,
                               input logic [7:0] d1, input int n);
        logic [7:0] rx;
        cs_low();
        header(8'hF0, addr, "R1 write");
        xfer(d0, rx); check("R6 write miso", rx, 8'h00);
        if (n > 1) begin xfer(d1, rx); check("R6 write miso", rx, 8'h00); end
        cs_high();
    endtask

    task automatic t_reset();
        check("R11 miso idle after reset", {7'd0, spi_miso}, 8'h00);
    endtask

    task automatic t_version();
        logic [7:0] rx;
        cs_low();
        header(8'h0F, 16'h0080, "R1 read");
        xfer(8'h00, rx); check("R7 id read", rx, 8'h51);
        cs_high();
    endtask

    task automatic t_burst();
        logic [7:0] rx;
        logic [7:0] pat [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        cs_low();
        header(8'hF0, 16'h0010, "R5");
        foreach (pat[i]) begin xfer(pat[i], rx); check("R6 write data miso", rx, 8'h00); end
        cs_high();
        cs_low();
        header(8'h0F, 16'h0010, "R4");
        foreach (pat[i]) begin xfer(8'hFF, rx); check("R4 R5 burst readback", rx, pat[i]); end
        cs_high();
        cs_low();
        header(8'h0F, 16'h8012, "R2");
        xfer(8'h00, rx); check("R2 top address bit ignored", rx, 8'h33);
        cs_high();
    endtask

    task automatic t_id_write();
        logic [7:0] rx;
        cs_low();
        header(8'hF0, 16'h007F, "R7");
        xfer(8'hAA, rx); xfer(8'hBB, rx); xfer(8'hCC, rx);
        cs_high();
        cs_low();
        header(8'h0F, 16'h007F, "R7");
        xfer(8'h00, rx); check("R7 before id", rx, 8'hAA);
        xfer(8'h00, rx); check("R7 id write ignored", rx, 8'h51);
        xfer(8'h00, rx); check("R7 after id", rx, 8'hCC);
        cs_high();
    endtask

    task automatic t_bad_opcode();
        logic [7:0] rx;
        cs_low();
        xfer(8'h55, rx); check("R8 bad op miso", rx, 8'h00);
        xfer(8'h00, rx); check("R8 bad op miso", rx, 8'h00);
        xfer(8'h10, rx); check("R8 bad op miso", rx, 8'h00);
        xfer(8'h99, rx); check("R8 bad op miso", rx, 8'h00);
        cs_high();
        cs_low();
        header(8'h0F, 16'h0010, "R8");
        xfer(8'h00, rx); check("R8 memory untouched", rx, 8'h11);
        cs_high();
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        cs_low();
        partial(8'hF0, 3);                 // cut inside the opcode
        cs_high();
        cs_low();
        header(8'hF0, 16'h0011, "R9");
        partial(8'h77, 4);                 // cut inside a data byte
        cs_high();
        cs_low();
        header(8'h0F, 16'h0011, "R9");
        xfer(8'h00, rx); check("R9 partial byte dropped", rx, 8'h22);
        cs_high();
    endtask

    task automatic t_wrap();
        logic [7:0] rx;
        write_bytes(16'h7FFF, 8'h5A, 8'h6B, 2);
        cs_low();
        header(8'h0F, 16'h0000, "R10");
        xfer(8'h00, rx); check("R10 wrap write to 0x0000", rx, 8'h6B);
        cs_high();
        cs_low();
        header(8'h0F, 16'h7FFF, "R10");
        xfer(8'h00, rx); check("R10 first of wrap burst", rx, 8'h5A);
        for (int i = 1; i <= 16'h81; i++) begin
            xfer(8'h00, rx);
            if (i == 1)     check("R10 wrapped to 0x0000", rx, 8'h6B);
            if (i == 16'h80) check("R10 0x007F after wrap", rx, 8'hAA);
            if (i == 16'h81) check("R10 id after wrap", rx, 8'h51);
        end
        cs_high();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_version();
        t_burst();
        t_id_write();
        t_bad_opcode();
        t_abort();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule